// File: doc/BRIEF.md
# Serial-to-Quad Lane Format Converter

This block is a streaming datapath placed between a data mover and a serial controller whose shifter only handles four-lane nibbles. It rewrites payload bytes so that single-line serial traffic can still go through that controller. In expand mode each serial bit becomes one nibble, with the bit on lane 0 and the other three lanes at zero. In compact mode it goes the other way: one serial bit is recovered from lane 1 of each received nibble. A third mode reverses the byte order inside 32-bit words. A short word at the end of the payload is reversed over its own length.

A job begins with a one-cycle `start` pulse. The mode and a length are sampled on that pulse. The length is given in serial bit cycles. Bytes come in and go out on valid/ready streams. The block holds at most one word: it fills the word with one input group, then drains the converted output group. When the final output byte has been accepted, `done` pulses for one cycle.

Top module: `lane_fmt_conv`

## Requirements
- R1: After reset `in_ready`, `out_valid`, `busy` and `done` are all 0, and they stay 0 while no job runs.
- R2: Expand (mode 2'b00): serial bit i is bit 7-(i mod 8) of input byte i/8, so each byte is sent MSB first. Output stream bit 4*i carries serial bit i. Every other output bit is 0. Stream bits are numbered LSB first within a byte, and bytes in order of transfer.
- R3: Compact (mode 2'b01): output stream bit i equals input stream bit 4*i+1, the lane-1 bit of nibble i. Bits are numbered the same way as in R2.
- R4: Reorder (mode[1] = 1): each complete group of 4 bytes comes out in reversed byte order.
- R5: In reorder mode, a final group shorter than 4 bytes is reversed over its own length. One byte passes unchanged, two bytes swap, three bytes come out as the third, then the second, then the first.
- R6: Length, with C = `count` in bits. Expand takes ceil(C/8) input bytes and gives ceil(C/2) output bytes. Compact takes ceil(C/2) and gives ceil(C/8). Reorder takes and gives ceil(C/8). Output bits at serial positions at or beyond C read as 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. No byte is lost or repeated under any ready pattern.
- R8: `done` is a single-cycle pulse. It rises in the cycle after the last output byte is accepted, and `busy` is low from that same cycle. A `start` with C = 0 gives a `done` pulse on the next cycle with no traffic.
- R9: The mode is held from `start` to `done`. Changes on `mode`, `count` or `start` while `busy` is high have no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job, sampled when idle |
| mode | input | 2 | 00 expand, 01 compact, 1x reorder |
| count | input | CNT_W | Job length in serial bit cycles |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink accepts the output byte |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench sends single-bit-set bytes through expand and compact mode. These show whether the bit reversal and the lane position are right, and not just whether some bit arrives. Reorder lengths of 1, 2, 3, 4 and 5 bytes separate the tail handling from the full-word swap. Lengths that are not a multiple of 8 or 2 test the rounding of the output length and the zeroing of bits past the length. Random payloads, random lengths and random stalls on both streams, together with mode and start toggling during jobs, cover backpressure and mode holding.

// File: rtl/lane_fmt_pkg.sv
package lane_fmt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_DRAIN = 2'd2
   } lane_st_e;

   localparam logic [1:0] MODE_EXPAND  = 2'b00;
   localparam logic [1:0] MODE_COMPACT = 2'b01;

   // Mirror the bit order of one byte
   function automatic logic [7:0] bitrev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

endpackage

// File: rtl/lane_fmt_xform.sv
module lane_fmt_xform
   import lane_fmt_pkg::*;
#(
   parameter int WORD_BYTES = 4
) (
   input  logic [1:0]              mode,
   input  logic [WORD_BYTES*8-1:0] word_i,
   input  logic [3:0]              sbits,
   input  logic [2:0]              gsize,
   output logic [WORD_BYTES*8-1:0] word_o
);

   localparam int WORD_W = WORD_BYTES * 8;

   if (WORD_BYTES != 4) begin : g_bad_word
      $error("lane_fmt_xform: WORD_BYTES must be 4 (one byte spreads to four lanes)");
   end

   logic [8:0] mask9;
   logic [7:0] smask;
   logic [7:0] rev_m;
   logic [7:0] cbits;

   assign mask9 = (9'd1 << sbits) - 9'd1;
   assign smask = mask9[7:0];
   assign rev_m = bitrev8(word_i[7:0]) & smask;

   // Lane-1 pick of each nibble for compact mode
   for (genvar i = 0; i < 8; i++) begin : g_cbit
      assign cbits[i] = word_i[4*i+1] & smask[i];
   end

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
      logic [7:0] exp_b;
      logic [7:0] cmp_b;
      logic [7:0] ord_b;
      logic [2:0] src;

      always_comb begin
         exp_b    = 8'h00;
         exp_b[0] = rev_m[2*k];
         exp_b[4] = rev_m[2*k+1];
      end

      if (k == 0) begin : g_cmp_lo
         assign cmp_b = cbits;
      end else begin : g_cmp_hi
         assign cmp_b = 8'h00;
      end

      always_comb begin
         src   = gsize - 3'd1 - 3'(k);
         ord_b = 8'h00;
         if (3'(k) < gsize) ord_b = word_i[{src[1:0], 3'b000} +: 8];
      end

      assign word_o[8*k +: 8] = mode[1] ? ord_b : (mode[0] ? cmp_b : exp_b);
   end

   logic unused_w;
   assign unused_w = ^word_i[WORD_W-1:WORD_W-2];

endmodule

// File: rtl/lane_fmt_ctrl.sv
module lane_fmt_ctrl
   import lane_fmt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [1:0]              mode,
   input  logic [CNT_W-1:0]        count,
   input  logic                    in_valid,
   input  logic [7:0]              in_data,
   output logic                    in_ready,
   output logic                    out_valid,
   output logic [7:0]              out_data,
   input  logic                    out_ready,
   output logic                    busy,
   output logic                    done,
   output logic [1:0]              mode_q_o,
   output logic [WORD_BYTES*8-1:0] word_o,
   output logic [3:0]              sbits_o,
   output logic [2:0]              gsize_o,
   input  logic [WORD_BYTES*8-1:0] xf_word_i
);

   if (CNT_W < 6) begin : g_bad_cnt
      $error("lane_fmt_ctrl: CNT_W must be at least 6");
   end
   if (WORD_BYTES != 4) begin : g_bad_word
      $error("lane_fmt_ctrl: WORD_BYTES must be 4");
   end

   localparam int WORD_W = WORD_BYTES * 8;

   lane_st_e           state;
   logic [1:0]         mode_q;
   logic [CNT_W-1:0]   bits_rem;
   logic [WORD_W-1:0]  buf_q;
   logic [1:0]         in_idx;
   logic [1:0]         out_idx;
   logic               done_q;

   logic [3:0]         sbits;
   logic [2:0]         half;
   logic [CNT_W:0]     rb_full;
   logic [2:0]         gsize;
   logic [2:0]         gin;
   logic [2:0]         gout;
   logic [CNT_W-1:0]   step;
   logic [CNT_W-1:0]   next_rem;

   // Group sizing from the bits still to go
   always_comb begin
      sbits   = (bits_rem >= CNT_W'(8)) ? 4'd8 : bits_rem[3:0];
      half    = 3'((sbits + 4'd1) >> 1);
      rb_full = ({1'b0, bits_rem} + (CNT_W+1)'(7)) >> 3;
      gsize   = (rb_full >= (CNT_W+1)'(WORD_BYTES)) ? 3'(WORD_BYTES) : rb_full[2:0];
      case (mode_q)
         MODE_EXPAND:  begin gin = 3'd1;  gout = half;  end
         MODE_COMPACT: begin gin = half;  gout = 3'd1;  end
         default:      begin gin = gsize; gout = gsize; end
      endcase
      step     = mode_q[1] ? CNT_W'(32) : CNT_W'(8);
      next_rem = (bits_rem > step) ? (bits_rem - step) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mode_q   <= MODE_EXPAND;
         bits_rem <= '0;
         buf_q    <= '0;
         in_idx   <= '0;
         out_idx  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  mode_q   <= mode;
                  bits_rem <= count;
                  buf_q    <= '0;
                  in_idx   <= '0;
                  out_idx  <= '0;
                  if (count == '0) done_q <= 1'b1;
                  else             state  <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (in_valid) begin
                  buf_q[{in_idx, 3'b000} +: 8] <= in_data;
                  if ({1'b0, in_idx} == gin - 3'd1) begin
                     state   <= ST_DRAIN;
                     out_idx <= '0;
                  end else begin
                     in_idx <= in_idx + 2'd1;
                  end
               end
            end
            ST_DRAIN: begin
               if (out_ready) begin
                  if ({1'b0, out_idx} == gout - 3'd1) begin
                     bits_rem <= next_rem;
                     buf_q    <= '0;
                     in_idx   <= '0;
                     if (next_rem == '0) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        state <= ST_FILL;
                     end
                  end else begin
                     out_idx <= out_idx + 2'd1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state == ST_FILL);
   assign out_valid = (state == ST_DRAIN);
   assign out_data  = xf_word_i[{out_idx, 3'b000} +: 8];
   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign mode_q_o  = mode_q;
   assign word_o    = buf_q;
   assign sbits_o   = sbits;
   assign gsize_o   = gsize;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!in_ready && !out_valid));                              // R1
   AST_EXPAND_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode_q == MODE_EXPAND) |-> ((out_data & 8'hEE) == 8'h00)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R8
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));                        // R9

endmodule

// File: rtl/lane_fmt_conv.sv
module lane_fmt_conv
   import lane_fmt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] count,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready,
   output logic             busy,
   output logic             done
);

   localparam int WORD_W = WORD_BYTES * 8;

   logic [1:0]        mode_q;
   logic [WORD_W-1:0] word_raw;
   logic [WORD_W-1:0] word_cvt;
   logic [3:0]        sbits;
   logic [2:0]        gsize;

   lane_fmt_ctrl #(
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .count     (count),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready),
      .busy      (busy),
      .done      (done),
      .mode_q_o  (mode_q),
      .word_o    (word_raw),
      .sbits_o   (sbits),
      .gsize_o   (gsize),
      .xf_word_i (word_cvt)
   );

   lane_fmt_xform #(
      .WORD_BYTES (WORD_BYTES)
   ) xform_i (
      .mode   (mode_q),
      .word_i (word_raw),
      .sbits  (sbits),
      .gsize  (gsize),
      .word_o (word_cvt)
   );

endmodule

// File: tb/lane_fmt_conv_tb.sv
`timescale 1ns/1ps
module lane_fmt_conv_tb_top;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       mode = 2'b00;
   logic [CNT_W-1:0] count = '0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             in_ready;
   logic             out_valid;
   logic [7:0]       out_data;
   logic             out_ready = 1'b0;
   logic             busy;
   logic             done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] in_mem  [256];
   logic [7:0] exp_mem [256];
   logic [7:0] got_mem [256];

   always #2.5 clk = ~clk;

   lane_fmt_conv #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
         $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int in_len(input logic [1:0] md, input int c);
      if (md == 2'b01) return (c + 1) / 2;
      return (c + 7) / 8;
   endfunction

   // Reference model built from the requirement text
   function automatic int build_exp(input logic [1:0] md, input int c);
      int n;
      if (md[1]) begin
         n = (c + 7) / 8;
         for (int k = 0; k < n; k++) begin
            int base = (k / 4) * 4;
            int gs = (n - base < 4) ? n - base : 4;
            exp_mem[k] = in_mem[base + gs - 1 - (k - base)];
         end
      end else if (md == 2'b00) begin
         n = (c + 1) / 2;
         for (int k = 0; k < n; k++) exp_mem[k] = 8'h00;
         for (int i = 0; i < c; i++) begin
            logic s = in_mem[i / 8][7 - (i % 8)];
            exp_mem[(4 * i) / 8][(4 * i) % 8] = s;
         end
      end else begin
         n = (c + 7) / 8;
         for (int k = 0; k < n; k++) exp_mem[k] = 8'h00;
         for (int i = 0; i < c; i++)
            exp_mem[i / 8][i % 8] = in_mem[(4 * i + 1) / 8][(4 * i + 1) % 8];
      end
      return n;
   endfunction

   task automatic run_job(input logic [1:0] md, input int c, input string req,
                          input bit stall, input bit disturb);
      int nin = in_len(md, c);
      int nexp = build_exp(md, c);
      int fed = 0;
      int ng = 0;
      int lim = 0;
      int bad = -1;
      @(negedge clk);
      start = 1'b1; mode = md; count = CNT_W'(c);
      @(negedge clk);
      start = 1'b0;
      while (!done) begin
         if (disturb) begin
            mode  = 2'($urandom);
            count = CNT_W'($urandom);
            start = ($urandom % 3 == 0);
         end
         in_valid = (fed < nin) && (!stall || ($urandom % 4 != 0));
         in_data  = (fed < nin) ? in_mem[fed] : 8'hXX;
         if (in_valid && in_ready) fed++;
         out_ready = !stall || ($urandom % 3 != 0);
         if (out_valid && out_ready) begin
            if (ng < 256) got_mem[ng] = out_data;
            ng++;
         end
         @(negedge clk);
         lim++;
         if (lim > 4000) break;
      end
      start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      check(done == 1'b1, {req, " R8 done seen"}, done, 1);
      check(busy == 1'b0, {req, " R8 idle at done"}, busy, 0);
      check(fed == nin, {req, " R6 input bytes"}, fed, nin);
      check(ng == nexp, {req, " R6 output bytes"}, ng, nexp);
      for (int k = 0; k < nexp && k < ng; k++)
         if (bad < 0 && got_mem[k] !== exp_mem[k]) bad = k;
      if (bad >= 0) check(1'b0, {req, " data"}, got_mem[bad], exp_mem[bad]);
      else          check(1'b1, {req, " data"}, 0, 0);
      @(negedge clk);
      check(done == 1'b0, {req, " R8 done single pulse"}, done, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(in_ready == 0 && out_valid == 0 && busy == 0 && done == 0,
            "R1 reset outputs", {in_ready, out_valid, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(in_ready == 0 && out_valid == 0 && busy == 0 && done == 0,
            "R1 idle after reset", {in_ready, out_valid, busy, done}, 0);

      // R2: single bit 0 of byte is serial bit 7 -> output bit 28
      in_mem[0] = 8'h01;
      run_job(2'b00, 8, "R2 expand lsb", 0, 0);
      check(exp_mem[3] == 8'h10, "R2 model byte3", exp_mem[3], 8'h10);
      in_mem[0] = 8'h80; in_mem[1] = 8'hA5;
      run_job(2'b00, 16, "R2 expand msb", 1, 0);
      // R6: partial byte in expand
      in_mem[0] = 8'hFF;
      run_job(2'b00, 3, "R6 expand 3 bits", 0, 0);

      // R3: lane-1 recovery
      in_mem[0] = 8'h02; in_mem[1] = 8'h20; in_mem[2] = 8'hDD; in_mem[3] = 8'h22;
      run_job(2'b01, 8, "R3 compact lane1", 0, 0);
      in_mem[0] = 8'hFD; in_mem[1] = 8'hDF; in_mem[2] = 8'h02;
      run_job(2'b01, 5, "R6 compact 5 bits", 1, 0);

      // R4/R5: reorder full words and every tail length
      for (int i = 0; i < 8; i++) in_mem[i] = 8'(8'h11 * (i + 1));
      run_job(2'b10, 32, "R4 reorder word", 0, 0);
      run_job(2'b11, 64, "R4 reorder two words", 1, 0);
      run_job(2'b10, 8,  "R5 tail 1", 0, 0);
      run_job(2'b10, 16, "R5 tail 2", 0, 0);
      run_job(2'b10, 24, "R5 tail 3", 1, 0);
      run_job(2'b10, 40, "R5 word plus tail 1", 1, 0);
      run_job(2'b10, 13, "R6 reorder rounded", 0, 0);

      // R8: zero length
      @(negedge clk);
      start = 1'b1; mode = 2'b00; count = '0;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R8 zero length done", done, 1);
      check(out_valid == 1'b0 && busy == 1'b0, "R8 zero length no traffic", {out_valid, busy}, 0);
      @(negedge clk);
      check(done == 1'b0, "R8 zero length pulse", done, 0);

      // R9 and R7: random jobs with stalls and input disturbance
      for (int j = 0; j < 40; j++) begin
         logic [1:0] md = 2'($urandom);
         int c = 1 + ($urandom % 200);
         for (int i = 0; i < 256; i++) in_mem[i] = 8'($urandom);
         run_job(md, c, (j % 2) ? "R9 random disturbed" : "R7 random stalled",
                 1, (j % 2) == 1);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule